// File: doc/BRIEF.md
# Virtually-Indexed Physically-Tagged Data Cache

This block is a 32 KB write-back data cache. It has two ways and 64-byte lines, which gives 256 sets. The set number is formed entirely from address bits known before translation. The six low set bits are address bits [11:6], which lie inside the 4 KB page offset. The two high set bits are the two lowest virtual page number bits, virtual address bits [13:12]. The set can therefore be read in the cycle the request is accepted, while an external translator works out the physical frame number. The processor supplies that frame number in the following cycle. It is compared against the physical tags of both ways, and the block answers hit or miss in the same cycle.

Each stored tag holds physical address bits [31:12]. Its two low bits may therefore differ from the two virtual colour bits that picked the set. A miss allocates the line in the virtually indexed set, under the physical tag. A modified victim is first written out over a simple line-wide memory port, and then the refill is read. A store miss allocates the line and merges the store word into the refilled data. A snoop-invalidate names a physical line. Because the colour of that line is unknown, the block visits all four candidate sets. It writes back each modified copy it finds and then invalidates it.

Top module: `vipt_cache`

## Requirements
- R1: After reset, req_ready and snp_ready are 1, resp_valid and mem_req_valid are 0, and every line is invalid, so the first access of any address misses.
- R2: A request accepted on a clock edge (req_valid and req_ready both 1) gets resp_valid on the very next cycle, with xlat_pfn sampled in that cycle. On a hit, resp_rdata is the 32-bit word selected by vaddr[5:2], where word k of a line sits in bits [32k+31:32k].
- R3: The set index is {vaddr[13:12], vaddr[11:6]} and the stored tag is the frame number. The same frame reached with different vaddr[13:12] bits misses, and the same set with a different frame number misses.
- R4: A miss is reported with resp_hit 0. Next comes a read request on the memory port at address {frame, vaddr[11:6], 6'b0}. Requests are blocked until mem_rsp_valid delivers the line, and afterwards the same access hits.
- R5: A store hit writes req_wdata into the selected word, marks the line modified and causes no memory traffic. A later load returns the stored word.
- R6: A store miss refills the line, merges the store word into it and marks it modified. The other words keep their refilled values.
- R7: The victim is an invalid way if one exists, otherwise the least recently used way of the set. Hits and refills make the touched way the most recently used.
- R8: A modified victim is sent as a write request carrying the whole line at {old tag, set low bits, 6'b0} before the refill read request. A clean victim causes no write. Each memory request holds its address and kind until mem_req_ready.
- R9: A snoop of a physical line searches all four colours. A modified copy is written back and then invalidated, and a clean copy is invalidated with no traffic. snp_done pulses once the search ends, and the next access to that line misses.
- R10: When snp_valid and req_valid are both high while the block is idle, the snoop is taken first: req_ready is 0 that cycle and no response appears until the snoop ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = store, 0 = load |
| req_vaddr | input | 32 | Virtual byte address |
| req_wdata | input | 32 | Store word |
| xlat_pfn | input | 20 | Physical frame number, valid the cycle after acceptance |
| resp_valid | output | 1 | Lookup result valid |
| resp_hit | output | 1 | 1 = hit, 0 = miss |
| resp_rdata | output | 32 | Load word on a hit, zero otherwise |
| mem_req_valid | output | 1 | Memory line request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = line writeback, 0 = line read |
| mem_req_addr | output | 32 | Line-aligned physical address |
| mem_req_wline | output | 512 | Writeback line data |
| mem_rsp_valid | input | 1 | Refill line present |
| mem_rsp_line | input | 512 | Refill line data |
| snp_valid | input | 1 | Snoop-invalidate request |
| snp_ready | output | 1 | Snoop accepted when high with snp_valid |
| snp_paddr | input | 32 | Physical address of the snooped line |
| snp_done | output | 1 | One-cycle pulse when the snoop search ends |

## Verification
The hit or miss answer is due in the cycle after the accepting edge. The bench drives the frame number just after that edge and reads resp_valid, resp_hit and resp_rdata at the next falling edge, so a one-cycle slip in either direction fails. Memory requests are recorded at the edge where they are accepted. The bench compares their order, addresses and line contents only once the block is idle again, and checks that none appeared across a store hit or a clean snoop. snp_done is looked for at each falling edge after the snoop is accepted. For the snoop-priority case, req_ready and resp_valid are sampled in the same cycle the snoop is taken and in the cycle after.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

  localparam int DEF_ADDR_W     = 32;
  localparam int DEF_LINE_BYTES = 64;
  localparam int DEF_SETS       = 256;
  localparam int DEF_PAGE_BYTES = 4096;
  localparam int DEF_WORD_W     = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WB,
    ST_RFQ,
    ST_RFW,
    ST_SLOOK,
    ST_SWB
  } cache_state_e;

endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store #(
  parameter int TAG_W = 20,
  parameter int IDX_W = 8,
  parameter int WAYS  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [IDX_W-1:0]            idx,
  input  logic [TAG_W-1:0]            cmp_tag,
  input  logic                        wr_en,
  input  logic [$clog2(WAYS)-1:0]     wr_way,
  input  logic [TAG_W-1:0]            wr_tag,
  input  logic                        wr_valid,
  input  logic                        wr_dirty,
  output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
  output logic [WAYS-1:0]             rd_valid,
  output logic [WAYS-1:0]             rd_dirty,
  output logic [WAYS-1:0]             hit_vec
);

  localparam int SETS  = 1 << IDX_W;
  localparam int WAY_W = $clog2(WAYS);

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    logic [TAG_W-1:0] tag_mem [SETS];
    logic [SETS-1:0]  vld_q, vld_d;
    logic [SETS-1:0]  dty_q, dty_d;
    logic             sel;

    assign sel = wr_en && (wr_way == WAY_W'(g));

    always_ff @(posedge clk) begin
      if (sel) tag_mem[idx] <= wr_tag;
    end

    always_comb begin
      vld_d = vld_q;
      dty_d = dty_q;
      if (sel) begin
        vld_d[idx] = wr_valid;
        dty_d[idx] = wr_dirty;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= '0;
        dty_q <= '0;
      end else begin
        vld_q <= vld_d;
        dty_q <= dty_d;
      end
    end

    assign rd_tag[g]   = tag_mem[idx];
    assign rd_valid[g] = vld_q[idx];
    assign rd_dirty[g] = dty_q[idx];
    assign hit_vec[g]  = vld_q[idx] && (tag_mem[idx] == cmp_tag);
  end

  // R3: a physical tag is present at most once per set, so a hit names one way
  a_r3_hit_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  if (WAYS == 2) begin : g_pair_chk
    // R7: allocation only follows a miss, so two valid ways never share a tag
    a_r7_no_dup_tag: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid[0] && rd_valid[1]) |-> (rd_tag[0] != rd_tag[1]));
  end

endmodule

// File: rtl/vipt_data_store.sv
module vipt_data_store #(
  parameter int LINE_W = 512,
  parameter int IDX_W  = 8,
  parameter int WAYS   = 2
) (
  input  logic                        clk,
  input  logic [IDX_W-1:0]            idx,
  input  logic                        wr_en,
  input  logic [$clog2(WAYS)-1:0]     wr_way,
  input  logic [LINE_W-1:0]           wr_line,
  output logic [WAYS-1:0][LINE_W-1:0] rd_line
);

  localparam int SETS  = 1 << IDX_W;
  localparam int WAY_W = $clog2(WAYS);

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    logic [LINE_W-1:0] line_mem [SETS];

    always_ff @(posedge clk) begin
      if (wr_en && (wr_way == WAY_W'(g))) line_mem[idx] <= wr_line;
    end

    assign rd_line[g] = line_mem[idx];
  end

endmodule

// File: rtl/vipt_lru.sv
module vipt_lru #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic             touch_en,
  input  logic             touch_way,
  output logic             lru_way
);

  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0] old_q, old_d;

  always_comb begin
    old_d = old_q;
    if (touch_en) old_d[idx] = ~touch_way;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) old_q <= '0;
    else        old_q <= old_d;
  end

  assign lru_way = old_q[idx];

endmodule

// File: rtl/vipt_cache.sv
module vipt_cache
  import vipt_pkg::*;
#(
  parameter int ADDR_W     = DEF_ADDR_W,
  parameter int LINE_BYTES = DEF_LINE_BYTES,
  parameter int SETS       = DEF_SETS,
  parameter int PAGE_BYTES = DEF_PAGE_BYTES,
  parameter int WORD_W     = DEF_WORD_W
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                req_valid,
  output logic                                req_ready,
  input  logic                                req_write,
  input  logic [ADDR_W-1:0]                   req_vaddr,
  input  logic [WORD_W-1:0]                   req_wdata,
  input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] xlat_pfn,
  output logic                                resp_valid,
  output logic                                resp_hit,
  output logic [WORD_W-1:0]                   resp_rdata,
  output logic                                mem_req_valid,
  input  logic                                mem_req_ready,
  output logic                                mem_req_write,
  output logic [ADDR_W-1:0]                   mem_req_addr,
  output logic [LINE_BYTES*8-1:0]             mem_req_wline,
  input  logic                                mem_rsp_valid,
  input  logic [LINE_BYTES*8-1:0]             mem_rsp_line,
  input  logic                                snp_valid,
  output logic                                snp_ready,
  input  logic [ADDR_W-1:0]                   snp_paddr,
  output logic                                snp_done
);

  localparam int OFF_W    = $clog2(LINE_BYTES);
  localparam int IDX_W    = $clog2(SETS);
  localparam int PG_W     = $clog2(PAGE_BYTES);
  localparam int IDX_LO_W = PG_W - OFF_W;
  localparam int COLOR_W  = IDX_W - IDX_LO_W;
  localparam int TAG_W    = ADDR_W - PG_W;
  localparam int LINE_W   = LINE_BYTES * 8;
  localparam int BSEL_W   = $clog2(WORD_W / 8);
  localparam int WSEL_W   = OFF_W - BSEL_W;
  localparam int WAYS     = 2;

  cache_state_e state_q, state_d;

  logic [IDX_W-1:0]  op_idx_q, op_idx_d;
  logic [WSEL_W-1:0] op_word_q, op_word_d;
  logic              op_write_q, op_write_d;
  logic [WORD_W-1:0] op_wdata_q, op_wdata_d;
  logic [TAG_W-1:0]  ptag_q, ptag_d;
  logic [TAG_W-1:0]  stag_q, stag_d;
  logic              vic_q, vic_d;

  logic                        tag_wr_en, tag_wr_valid, tag_wr_dirty;
  logic                        tag_wr_way;
  logic [TAG_W-1:0]            tag_wr_tag;
  logic                        data_wr_en, data_wr_way;
  logic [LINE_W-1:0]           data_wr_line;
  logic                        lru_touch, lru_touch_way, lru_way;
  logic [WAYS-1:0][TAG_W-1:0]  rd_tag;
  logic [WAYS-1:0]             rd_valid, rd_dirty, hit_vec;
  logic [WAYS-1:0][LINE_W-1:0] rd_line;
  logic [TAG_W-1:0]            cmp_tag;

  logic                  any_hit, hit_way, in_snoop, color_last;
  logic [IDX_LO_W-1:0]   idx_lo;
  logic [IDX_W-1:0]      next_color_idx;
  logic                  unused_bits;

  assign unused_bits = ^{req_vaddr[ADDR_W-1:OFF_W+IDX_W], req_vaddr[BSEL_W-1:0],
                         snp_paddr[OFF_W-1:0]};

  function automatic logic [LINE_W-1:0] put_word(input logic [LINE_W-1:0] line,
                                                 input logic [WSEL_W-1:0] sel,
                                                 input logic [WORD_W-1:0] w);
    logic [LINE_W-1:0] r;
    r = line;
    r[sel*WORD_W +: WORD_W] = w;
    return r;
  endfunction

  assign any_hit        = |hit_vec;
  assign hit_way        = hit_vec[1];
  assign in_snoop       = (state_q == ST_SLOOK) || (state_q == ST_SWB);
  assign cmp_tag        = in_snoop ? stag_q : xlat_pfn;
  assign idx_lo         = op_idx_q[IDX_LO_W-1:0];
  assign color_last     = &op_idx_q[IDX_W-1:IDX_LO_W];
  assign next_color_idx = {op_idx_q[IDX_W-1:IDX_LO_W] + {{(COLOR_W-1){1'b0}}, 1'b1}, idx_lo};

  assign snp_ready = (state_q == ST_IDLE);
  assign req_ready = (state_q == ST_IDLE) && !snp_valid;

  always_comb begin
    state_d      = state_q;
    op_idx_d     = op_idx_q;
    op_word_d    = op_word_q;
    op_write_d   = op_write_q;
    op_wdata_d   = op_wdata_q;
    ptag_d       = ptag_q;
    stag_d       = stag_q;
    vic_d        = vic_q;
    tag_wr_en    = 1'b0;
    tag_wr_way   = vic_q;
    tag_wr_tag   = ptag_q;
    tag_wr_valid = 1'b0;
    tag_wr_dirty = 1'b0;
    data_wr_en   = 1'b0;
    data_wr_way  = vic_q;
    data_wr_line = mem_rsp_line;
    lru_touch     = 1'b0;
    lru_touch_way = vic_q;
    resp_valid    = 1'b0;
    resp_hit      = 1'b0;
    resp_rdata    = '0;
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_addr  = {ptag_q, idx_lo, {OFF_W{1'b0}}};
    mem_req_wline = rd_line[vic_q];
    snp_done      = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (snp_valid) begin
          op_idx_d = {{COLOR_W{1'b0}}, snp_paddr[PG_W-1:OFF_W]};
          stag_d   = snp_paddr[ADDR_W-1:PG_W];
          state_d  = ST_SLOOK;
        end else if (req_valid) begin
          op_idx_d   = req_vaddr[OFF_W+IDX_W-1:OFF_W];
          op_word_d  = req_vaddr[OFF_W-1:BSEL_W];
          op_write_d = req_write;
          op_wdata_d = req_wdata;
          state_d    = ST_LOOK;
        end
      end

      ST_LOOK: begin
        resp_valid = 1'b1;
        resp_hit   = any_hit;
        if (any_hit) begin
          resp_rdata    = rd_line[hit_way][op_word_q*WORD_W +: WORD_W];
          lru_touch     = 1'b1;
          lru_touch_way = hit_way;
          if (op_write_q) begin
            data_wr_en   = 1'b1;
            data_wr_way  = hit_way;
            data_wr_line = put_word(rd_line[hit_way], op_word_q, op_wdata_q);
            tag_wr_en    = 1'b1;
            tag_wr_way   = hit_way;
            tag_wr_tag   = rd_tag[hit_way];
            tag_wr_valid = 1'b1;
            tag_wr_dirty = 1'b1;
          end
          state_d = ST_IDLE;
        end else begin
          ptag_d = xlat_pfn;
          if (!rd_valid[0])      vic_d = 1'b0;
          else if (!rd_valid[1]) vic_d = 1'b1;
          else                   vic_d = lru_way;
          state_d = (rd_valid[vic_d] && rd_dirty[vic_d]) ? ST_WB : ST_RFQ;
        end
      end

      ST_WB: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = {rd_tag[vic_q], idx_lo, {OFF_W{1'b0}}};
        if (mem_req_ready) state_d = ST_RFQ;
      end

      ST_RFQ: begin
        mem_req_valid = 1'b1;
        if (mem_req_ready) state_d = ST_RFW;
      end

      ST_RFW: begin
        if (mem_rsp_valid) begin
          data_wr_en    = 1'b1;
          data_wr_line  = op_write_q ? put_word(mem_rsp_line, op_word_q, op_wdata_q)
                                     : mem_rsp_line;
          tag_wr_en     = 1'b1;
          tag_wr_valid  = 1'b1;
          tag_wr_dirty  = op_write_q;
          lru_touch     = 1'b1;
          state_d       = ST_IDLE;
        end
      end

      ST_SLOOK: begin
        if (any_hit && rd_dirty[hit_way]) begin
          vic_d   = hit_way;
          state_d = ST_SWB;
        end else begin
          if (any_hit) begin
            tag_wr_en  = 1'b1;
            tag_wr_way = hit_way;
            tag_wr_tag = stag_q;
          end
          if (color_last) begin
            snp_done = 1'b1;
            state_d  = ST_IDLE;
          end else begin
            op_idx_d = next_color_idx;
          end
        end
      end

      ST_SWB: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = {stag_q, idx_lo, {OFF_W{1'b0}}};
        if (mem_req_ready) begin
          tag_wr_en  = 1'b1;
          tag_wr_tag = stag_q;
          if (color_last) begin
            snp_done = 1'b1;
            state_d  = ST_IDLE;
          end else begin
            op_idx_d = next_color_idx;
            state_d  = ST_SLOOK;
          end
        end
      end

      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    op_idx_q   <= op_idx_d;
    op_word_q  <= op_word_d;
    op_write_q <= op_write_d;
    op_wdata_q <= op_wdata_d;
    ptag_q     <= ptag_d;
    stag_q     <= stag_d;
    vic_q      <= vic_d;
  end

  vipt_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W), .WAYS(WAYS)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx      (op_idx_q),
    .cmp_tag  (cmp_tag),
    .wr_en    (tag_wr_en),
    .wr_way   (tag_wr_way),
    .wr_tag   (tag_wr_tag),
    .wr_valid (tag_wr_valid),
    .wr_dirty (tag_wr_dirty),
    .rd_tag   (rd_tag),
    .rd_valid (rd_valid),
    .rd_dirty (rd_dirty),
    .hit_vec  (hit_vec)
  );

  vipt_data_store #(.LINE_W(LINE_W), .IDX_W(IDX_W), .WAYS(WAYS)) u_data (
    .clk     (clk),
    .idx     (op_idx_q),
    .wr_en   (data_wr_en),
    .wr_way  (data_wr_way),
    .wr_line (data_wr_line),
    .rd_line (rd_line)
  );

  vipt_lru #(.IDX_W(IDX_W)) u_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx       (op_idx_q),
    .touch_en  (lru_touch),
    .touch_way (lru_touch_way),
    .lru_way   (lru_way)
  );

  // R2: a lookup answer only ever follows an accepted request by one cycle
  a_r2_resp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(req_valid && req_ready));

  // R4: a reported miss is followed at once by a memory request
  a_r4_miss_then_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_hit) |=> mem_req_valid);

  // R8: a pending memory request keeps its kind and address until taken
  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

  // R10: a taken snoop leaves no lookup answer in the following cycle
  a_r10_snoop_first: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_ready) |=> !resp_valid);

endmodule

// File: tb/vipt_cache_bench.sv
module vipt_cache_bench;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid, req_write;
  logic         req_ready;
  logic [31:0]  req_vaddr, req_wdata;
  logic [19:0]  xlat_pfn;
  logic         resp_valid, resp_hit;
  logic [31:0]  resp_rdata;
  logic         mem_req_valid, mem_req_write;
  logic         mem_req_ready;
  logic [31:0]  mem_req_addr;
  logic [511:0] mem_req_wline;
  logic         mem_rsp_valid;
  logic [511:0] mem_rsp_line;
  logic         snp_valid, snp_ready, snp_done;
  logic [31:0]  snp_paddr;

  int tests = 0;
  int fails = 0;

  logic         ev_wr   [32];
  logic [31:0]  ev_addr [32];
  logic [511:0] ev_line [32];
  int           ev_n;
  int           rsp_cd;
  logic [31:0]  rd_addr;

  always #5 clk = ~clk;

  vipt_cache u_vipt_cache (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_vaddr(req_vaddr), .req_wdata(req_wdata), .xlat_pfn(xlat_pfn),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_rdata(resp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wline(mem_req_wline), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_line(mem_rsp_line), .snp_valid(snp_valid), .snp_ready(snp_ready),
    .snp_paddr(snp_paddr), .snp_done(snp_done)
  );

  function automatic logic [31:0] pat_word(input logic [31:0] la, input int w);
    return {la[31:6], 6'b0} ^ (32'h0101_0101 * 32'(w + 1));
  endfunction

  function automatic logic [511:0] pat_line(input logic [31:0] la);
    logic [511:0] l;
    for (int w = 0; w < 16; w++) l[w*32 +: 32] = pat_word(la, w);
    return l;
  endfunction

  // memory model: accepts each request on its second cycle, refills two cycles later
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req_ready <= 1'b0;
      mem_rsp_valid <= 1'b0;
      mem_rsp_line  <= '0;
      rsp_cd        <= 0;
      ev_n          <= 0;
      rd_addr       <= '0;
    end else begin
      mem_req_ready <= mem_req_valid && !mem_req_ready;
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        ev_wr[ev_n % 32]   <= mem_req_write;
        ev_addr[ev_n % 32] <= mem_req_addr;
        ev_line[ev_n % 32] <= mem_req_wline;
        ev_n <= ev_n + 1;
        if (!mem_req_write) begin
          rsp_cd  <= 2;
          rd_addr <= mem_req_addr;
        end
      end else if (rsp_cd > 0) begin
        rsp_cd <= rsp_cd - 1;
        if (rsp_cd == 1) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_line  <= pat_line(rd_addr);
        end
      end
    end
  end

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!(snp_ready && req_ready)) @(negedge clk);
  endtask

  task automatic access(input bit wr, input logic [31:0] va, input logic [19:0] pfn,
                        input logic [31:0] wd, output bit hit, output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_vaddr = va; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0; xlat_pfn = pfn;
    @(negedge clk);
    check("R2", "resp_valid one cycle after accept", 64'(resp_valid), 64'd1);
    hit = resp_hit;
    rd  = resp_rdata;
    wait_idle();
  endtask

  task automatic snoop(input logic [31:0] pa);
    bit seen = 1'b0;
    @(negedge clk);
    snp_valid = 1'b1; snp_paddr = pa;
    while (!snp_ready) @(negedge clk);
    @(posedge clk);
    #1 snp_valid = 1'b0;
    for (int i = 0; i < 40 && !seen; i++) begin
      @(negedge clk);
      if (snp_done) seen = 1'b1;
    end
    check("R9", "snp_done pulse", 64'(seen), 64'd1);
    wait_idle();
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", "req_ready after reset", 64'(req_ready), 64'd1);
    check("R1", "snp_ready after reset", 64'(snp_ready), 64'd1);
    check("R1", "resp_valid after reset", 64'(resp_valid), 64'd0);
    check("R1", "mem_req_valid after reset", 64'(mem_req_valid), 64'd0);
  endtask

  task automatic t_cold_miss();
    bit h; logic [31:0] d; int n0;
    n0 = ev_n;
    access(1'b0, 32'h0000_1048, 20'h12345, '0, h, d);
    check("R1", "first access misses", 64'(h), 64'd0);
    check("R4", "one refill request", 64'(ev_n - n0), 64'd1);
    check("R4", "refill is a read", 64'(ev_wr[n0 % 32]), 64'd0);
    check("R4", "refill address", 64'(ev_addr[n0 % 32]), 64'h1234_5040);
    access(1'b0, 32'h0000_1048, 20'h12345, '0, h, d);
    check("R4", "hit after refill", 64'(h), 64'd1);
    check("R2", "load word 2", 64'(d), 64'(pat_word(32'h1234_5040, 2)));
    access(1'b0, 32'h0000_107C, 20'h12345, '0, h, d);
    check("R2", "load word 15", 64'(d), 64'(pat_word(32'h1234_5040, 15)));
  endtask

  task automatic t_index_and_lru();
    bit h; logic [31:0] d; int n0;
    n0 = ev_n;
    access(1'b0, 32'h0000_2048, 20'h12345, '0, h, d);
    check("R3", "other colour misses", 64'(h), 64'd0);
    check("R3", "same physical refill addr", 64'(ev_addr[n0 % 32]), 64'h1234_5040);
    access(1'b0, 32'h0000_1048, 20'h54321, '0, h, d);
    check("R3", "other frame same set misses", 64'(h), 64'd0);
    access(1'b0, 32'h0000_1048, 20'h12345, '0, h, d);
    check("R7", "invalid way used, first line kept", 64'(h), 64'd1);
    n0 = ev_n;
    access(1'b0, 32'h0000_1048, 20'h0AAAA, '0, h, d);
    check("R7", "third frame misses", 64'(h), 64'd0);
    check("R8", "clean victim: read only", 64'(ev_n - n0), 64'd1);
    check("R8", "clean victim: no write", 64'(ev_wr[n0 % 32]), 64'd0);
    access(1'b0, 32'h0000_1048, 20'h12345, '0, h, d);
    check("R7", "recently used line survives", 64'(h), 64'd1);
    access(1'b0, 32'h0000_1048, 20'h54321, '0, h, d);
    check("R7", "LRU line was evicted", 64'(h), 64'd0);
  endtask

  task automatic t_store_hit();
    bit h; logic [31:0] d; int n0;
    n0 = ev_n;
    access(1'b1, 32'h0000_1048, 20'h12345, 32'hDEAD_BEEF, h, d);
    check("R5", "store hit", 64'(h), 64'd1);
    check("R5", "no memory traffic", 64'(ev_n - n0), 64'd0);
    access(1'b0, 32'h0000_1048, 20'h12345, '0, h, d);
    check("R5", "stored word read back", 64'(d), 64'h0000_0000_DEAD_BEEF);
  endtask

  task automatic t_dirty_evict();
    bit h; logic [31:0] d; int n0;
    access(1'b0, 32'h0000_1048, 20'h54321, '0, h, d);
    check("R7", "touch other way", 64'(h), 64'd1);
    n0 = ev_n;
    access(1'b0, 32'h0000_1048, 20'h33333, '0, h, d);
    check("R8", "miss on new frame", 64'(h), 64'd0);
    check("R8", "two memory requests", 64'(ev_n - n0), 64'd2);
    check("R8", "first is writeback", 64'(ev_wr[n0 % 32]), 64'd1);
    check("R8", "writeback address", 64'(ev_addr[n0 % 32]), 64'h1234_5040);
    check("R8", "writeback word 2", 64'(ev_line[n0 % 32][2*32 +: 32]), 64'h0000_0000_DEAD_BEEF);
    check("R8", "writeback word 0", 64'(ev_line[n0 % 32][31:0]), 64'(pat_word(32'h1234_5040, 0)));
    check("R8", "then refill read", 64'(ev_wr[(n0 + 1) % 32]), 64'd0);
    check("R8", "refill address", 64'(ev_addr[(n0 + 1) % 32]), 64'h3333_3040);
    access(1'b0, 32'h0000_1048, 20'h33333, '0, h, d);
    check("R4", "new line data", 64'(d), 64'(pat_word(32'h3333_3040, 2)));
  endtask

  task automatic t_store_miss();
    bit h; logic [31:0] d; int n0;
    n0 = ev_n;
    access(1'b1, 32'h0000_0080, 20'h00777, 32'hCAFE_F00D, h, d);
    check("R6", "store miss", 64'(h), 64'd0);
    check("R6", "refill address", 64'(ev_addr[n0 % 32]), 64'h0077_7080);
    access(1'b0, 32'h0000_0080, 20'h00777, '0, h, d);
    check("R6", "merged word", 64'(d), 64'h0000_0000_CAFE_F00D);
    access(1'b0, 32'h0000_0084, 20'h00777, '0, h, d);
    check("R6", "neighbour word from refill", 64'(d), 64'(pat_word(32'h0077_7080, 1)));
  endtask

  task automatic t_snoop();
    bit h; logic [31:0] d; int n0;
    n0 = ev_n;
    snoop(32'h0077_7080);
    check("R9", "dirty snoop writes once", 64'(ev_n - n0), 64'd1);
    check("R9", "snoop writeback kind", 64'(ev_wr[n0 % 32]), 64'd1);
    check("R9", "snoop writeback addr", 64'(ev_addr[n0 % 32]), 64'h0077_7080);
    check("R9", "snoop writeback data", 64'(ev_line[n0 % 32][31:0]), 64'h0000_0000_CAFE_F00D);
    access(1'b0, 32'h0000_0080, 20'h00777, '0, h, d);
    check("R9", "invalidated line misses", 64'(h), 64'd0);
    access(1'b0, 32'h0000_3048, 20'h0BBBB, '0, h, d);
    n0 = ev_n;
    snoop(32'h0BBB_B040);
    snoop(32'h1234_5040);
    check("R9", "clean snoops cause no traffic", 64'(ev_n - n0), 64'd0);
    access(1'b0, 32'h0000_3048, 20'h0BBBB, '0, h, d);
    check("R9", "colour 3 copy invalidated", 64'(h), 64'd0);
    access(1'b0, 32'h0000_2048, 20'h12345, '0, h, d);
    check("R9", "colour 2 copy invalidated", 64'(h), 64'd0);
  endtask

  task automatic t_priority();
    bit seen = 1'b0;
    @(negedge clk);
    snp_valid = 1'b1; snp_paddr = 32'h0099_9000;
    req_valid = 1'b1; req_write = 1'b0; req_vaddr = 32'h0000_1048;
    #1;
    check("R10", "req_ready low under snoop", 64'(req_ready), 64'd0);
    @(posedge clk);
    #1 snp_valid = 1'b0;
    @(negedge clk);
    check("R10", "snoop taken", 64'(snp_ready), 64'd0);
    check("R10", "no lookup answer", 64'(resp_valid), 64'd0);
    if (snp_done) seen = 1'b1;
    while (!req_ready) begin
      @(negedge clk);
      if (snp_done) seen = 1'b1;
    end
    check("R10", "snoop ended first", 64'(seen), 64'd1);
    @(posedge clk);
    #1 req_valid = 1'b0; xlat_pfn = 20'h33333;
    @(negedge clk);
    check("R10", "held request served", 64'({resp_valid, resp_hit}), 64'd3);
    wait_idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hang expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_vaddr = '0; req_wdata = '0;
    xlat_pfn = '0; snp_valid = 1'b0; snp_paddr = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_cold_miss();
    t_index_and_lru();
    t_store_hit();
    t_dirty_evict();
    t_store_miss();
    t_snoop();
    t_priority();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule